// File: doc/BRIEF.md
# Banked Wiper and Data Register Controller

This block is the register side of a digitally controlled potentiometer. It keeps a volatile wiper position register and a sixteen-entry data register file, arranged as four banks of four words. It carries out requests that have already been decoded by a serial front end: reads, writes, and transfers in both directions between the wiper and a data register. It enforces the bank rules and the write-protect pin, and it models the slow non-volatile store time with a busy counter. The wiper value is decoded into a one-hot tap-select vector that drives the switches of a resistor ladder.

Each request is a one-cycle strobe. It carries a 3-bit opcode, a 2-bit bank index, a 2-bit word index within the bank, and a write byte. A store to the data register file raises `busy` for a parameterised number of cycles. While `busy` is high, every request is ignored. While reset is held, the wiper is reloaded from word 0 of bank 0. The data register file itself is not cleared by reset, which makes that recall meaningful.

Top module: `dpot_ctrl`

## Requirements
- R1: The data register file holds 16 independent words. The word address is `req_bank` (bank 0..3) concatenated with `req_sel` (word 0..3). A value written to one word reads back unchanged and leaves the other words untouched.
- R2: Opcode 2 reads a data register, and it is legal in any bank. Opcode 0 reads the wiper. A legal read raises `rd_valid` for the one cycle after the request edge, with the value on `rd_data`. Any other request leaves `rd_valid` low.
- R3: Opcode 1 writes `req_wdata` into the wiper. Opcodes 0 and 1 act only when `req_bank` is 0. With any other bank they are dropped: nothing changes and `rd_valid` stays low.
- R4: Opcode 4 copies data register (bank 0, word `req_sel`) into the wiper in the cycle after the request. When `req_bank` is not 0, the request is dropped.
- R5: Opcode 5 copies the wiper into data register (bank 0, word `req_sel`) and starts a store. When `req_bank` is not 0, the request is dropped and no store starts.
- R6: While `wp_n` is low, opcode 3 (data register write) and opcode 5 leave the data registers unchanged and do not raise `busy`. Wiper writes and reads still work.
- R7: An accepted data register change (opcode 3, or opcode 5 with `wp_n` high) holds `busy` high for exactly STORE_CYCLES cycles, starting the cycle after the request. `busy` is low after reset.
- R8: A request that arrives while `busy` is high has no effect on the wiper, the data registers or `rd_valid`.
- R9: While `rst` is high, the wiper loads data register (bank 0, word 0). The data registers keep their contents through reset.
- R10: `tap_sel` always has exactly one bit set, and that bit is bit number `wiper`. Wiper 00h selects bit 0, the low end of the ladder. Wiper FFh selects bit 255, the high end.
- R11: Opcodes 1 and 4 are volatile operations and never raise `busy`. Opcodes 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also performs wiper recall |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Request opcode (0..5, 6/7 no-op) |
| req_bank | input | 2 | Bank index |
| req_sel | input | 2 | Word index within the bank |
| req_wdata | input | 8 | Write byte for wiper or data register |
| wp_n | input | 1 | Write protect, active low; blocks data register stores |
| busy | output | 1 | Store cycle in progress |
| rd_valid | output | 1 | Read result valid for one cycle |
| rd_data | output | 8 | Read result |
| wiper | output | 8 | Current wiper position |
| tap_sel | output | 256 | One-hot ladder switch select |

## Verification
Most internal faults surface on `wiper` and `tap_sel` within one cycle of the request that exposes them. A wrong bank check or a missed write-protect gate leaves the wiper or a stored word off by the next edge. A corrupted data register file is hidden until a read, a load to the wiper, or a reset recall reaches the damaged word. For that reason the bench reads every word back and exercises recall after changing word 0. A miscounted store timer shows up as `busy` falling a cycle early or late, and as a request dropped or accepted at the edge of the window. The reference model therefore compares `busy` on every clock.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    typedef enum logic [2:0] {
        OP_RD_WIPER = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_RD_REG   = 3'd2,
        OP_WR_REG   = 3'd3,
        OP_LOAD     = 3'd4,
        OP_SAVE     = 3'd5,
        OP_NOP6     = 3'd6,
        OP_NOP7     = 3'd7
    } op_e;

    // Commands that touch the wiper are legal in bank 0 only.
    function automatic logic needs_bank0(op_e op);
        return (op == OP_RD_WIPER) || (op == OP_WR_WIPER) ||
               (op == OP_LOAD)     || (op == OP_SAVE);
    endfunction

    // Commands that change a data register (non-volatile store).
    function automatic logic is_store(op_e op);
        return (op == OP_WR_REG) || (op == OP_SAVE);
    endfunction

    function automatic logic is_read(op_e op);
        return (op == OP_RD_WIPER) || (op == OP_RD_REG);
    endfunction

    function automatic logic sets_wiper(op_e op);
        return (op == OP_WR_WIPER) || (op == OP_LOAD);
    endfunction

endpackage

// File: rtl/dpot_regfile.sv
module dpot_regfile #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];

    // Storage models non-volatile cells: no reset term.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (we && (waddr == ADDR_W'(g))) begin
                q <= wdata;
            end
        end
        assign words[g] = q;
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/dpot_store_timer.sv
module dpot_store_timer #(
    parameter int STORE_CYCLES = 500000,
    localparam int CNT_W = (STORE_CYCLES > 0) ? $clog2(STORE_CYCLES + 1) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end else if (start) begin
            cnt <= CNT_W'(STORE_CYCLES);
        end
    end

    assign busy = (cnt != '0);

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy) else $error("store started during busy"); // R8

endmodule

// File: rtl/dpot_tap_decode.sv
module dpot_tap_decode #(
    parameter int DATA_W = 8,
    localparam int TAPS = 1 << DATA_W
) (
    input  logic [DATA_W-1:0] pos,
    output logic [TAPS-1:0]   tap
);
    // Bit 0 is the low end of the ladder, bit TAPS-1 the high end.
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign tap[g] = (pos == DATA_W'(g));
    end

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int BANKS         = 4,
    parameter int REGS_PER_BANK = 4,
    parameter int STORE_CYCLES  = 500000,
    localparam int BANK_W = $clog2(BANKS),
    localparam int SEL_W  = $clog2(REGS_PER_BANK),
    localparam int ADDR_W = BANK_W + SEL_W,
    localparam int NREGS  = BANKS * REGS_PER_BANK,
    localparam int TAPS   = 1 << DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wp_n,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wiper,
    output logic [TAPS-1:0]   tap_sel
);
    op_e               op;
    logic              accept;
    logic              legal;
    logic              rf_we;
    logic [ADDR_W-1:0] rf_addr;
    logic [ADDR_W-1:0] rf_raddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] rf_rdata;
    logic              wiper_we;
    logic [DATA_W-1:0] wiper_d;
    logic              rd_fire;

    // Request decode
    always_comb begin
        op       = op_e'(req_op);
        accept   = req_valid && !busy;
        legal    = accept && (!needs_bank0(op) || (req_bank == '0));
        rf_addr  = {req_bank, req_sel};
        rf_raddr = rst ? '0 : rf_addr;
        rf_we    = legal && is_store(op) && wp_n;
        rf_wdata = (op == OP_SAVE) ? wiper : req_wdata;
        wiper_we = legal && sets_wiper(op);
        wiper_d  = (op == OP_LOAD) ? rf_rdata : req_wdata;
        rd_fire  = legal && is_read(op);
    end

    dpot_regfile #(
        .DATA_W(DATA_W),
        .DEPTH (NREGS)
    ) i_regfile (
        .clk  (clk),
        .we   (rf_we),
        .waddr(rf_addr),
        .wdata(rf_wdata),
        .raddr(rf_raddr),
        .rdata(rf_rdata)
    );

    dpot_store_timer #(
        .STORE_CYCLES(STORE_CYCLES)
    ) i_timer (
        .clk  (clk),
        .rst  (rst),
        .start(rf_we),
        .busy (busy)
    );

    // Wiper register with recall from bank 0 word 0 during reset
    always_ff @(posedge clk) begin
        if (rst) begin
            wiper <= rf_rdata;
        end else if (wiper_we) begin
            wiper <= wiper_d;
        end
    end

    // Read return
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) begin
                rd_data <= (op == OP_RD_WIPER) ? wiper : rf_rdata;
            end
        end
    end

    dpot_tap_decode #(
        .DATA_W(DATA_W)
    ) i_tap (
        .pos(wiper),
        .tap(tap_sel)
    );

    AST_TAP_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1) else $error("tap select not one-hot"); // R10
    AST_WP_BLOCKS_STORE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !wp_n) |=> !busy) else $error("store under write protect"); // R6
    AST_BUSY_FREEZES_WIPER: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wiper)) else $error("wiper moved while busy"); // R8
    AST_VOLATILE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_op == OP_WR_WIPER || req_op == OP_LOAD)) |=> !busy)
        else $error("volatile op raised busy"); // R11
    AST_BAD_BANK_KEEPS_WIPER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bank != '0 && needs_bank0(op_e'(req_op))) |=> $stable(wiper))
        else $error("illegal bank moved wiper"); // R4
    AST_RD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid)) else $error("read result without request"); // R2

    if (STORE_CYCLES > 0) begin : g_store_chk
        AST_STORE_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
            (req_valid && !busy && wp_n && req_op == OP_WR_REG) |=> busy)
            else $error("store did not raise busy"); // R7
    end

endmodule

// File: tb/test_dpot_ctrl.sv
module test_dpot_ctrl;
    localparam int STORE = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_bank = '0;
    logic [1:0]  req_sel = '0;
    logic [7:0]  req_wdata = '0;
    logic        wp_n = 1'b1;
    logic        busy;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [7:0]  wiper;
    logic [255:0] tap_sel;

    int errors = 0;
    int checks = 0;

    // Reference model state (-1 = unknown content)
    int m_reg [16];
    int m_wiper = -1;
    int m_busy = 0;
    int m_rdv = 0;
    int m_rd = -1;

    always #10 clk = ~clk;

    dpot_ctrl #(.STORE_CYCLES(STORE)) i_dpot_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_sel(req_sel), .req_wdata(req_wdata),
        .wp_n(wp_n), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .wiper(wiper), .tap_sel(tap_sel)
    );

    function automatic int pat(int i);
        return (i * 37 + 5) % 256;
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on each rising edge
    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = -1;
    end

    always @(posedge clk) begin
        int a;
        a = int'(req_bank) * 4 + int'(req_sel);
        if (rst) begin
            m_rdv = 0;
            m_busy = 0;
            m_wiper = m_reg[0];
        end else begin
            m_rdv = 0;
            if (m_busy > 0) begin
                m_busy--;
            end else if (req_valid) begin
                case (req_op)
                    3'd0: if (req_bank == 0) begin m_rdv = 1; m_rd = m_wiper; end
                    3'd1: if (req_bank == 0) m_wiper = int'(req_wdata);
                    3'd2: begin m_rdv = 1; m_rd = m_reg[a]; end
                    3'd3: if (wp_n) begin m_reg[a] = int'(req_wdata); m_busy = STORE; end
                    3'd4: if (req_bank == 0) m_wiper = m_reg[req_sel];
                    3'd5: if (req_bank == 0 && wp_n) begin
                              m_reg[req_sel] = m_wiper; m_busy = STORE;
                          end
                    default: ;
                endcase
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 busy", int'(busy), (m_busy > 0) ? 1 : 0);
            chk("R2 rd_valid", int'(rd_valid), m_rdv);
            if (m_rdv != 0 && m_rd >= 0) chk("R2 rd_data", int'(rd_data), m_rd);
            if (m_wiper >= 0) begin
                chk("R3 wiper", int'(wiper), m_wiper);
                chk("R10 tap bit", int'(tap_sel[m_wiper]), 1);
                chk("R10 tap count", $countones(tap_sel), 1);
            end
        end
    end

    task automatic do_req(int op, int bank, int sel, int data);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_bank  = 2'(bank);
        req_sel   = 2'(sel);
        req_wdata = 8'(data);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: got busy=%0d expected run to end", busy);
        finish_run();
    end

    initial begin
        int n;
        do_reset();
        chk("R7 reset busy", int'(busy), 0);
        chk("R2 reset rd_valid", int'(rd_valid), 0);

        // R1: fill all sixteen words
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 4; s++) begin
                do_req(3, b, s, pat(b * 4 + s));
                wait_idle();
            end
        for (int i = 0; i < 16; i++) begin
            do_req(2, i / 4, i % 4, 0);
            chk("R1 readback", int'(rd_data), pat(i));
            chk("R2 read valid", int'(rd_valid), 1);
        end

        // R9: recall of bank 0 word 0
        do_reset();
        chk("R9 recall", int'(wiper), pat(0));

        // R10 / R3 / R11: wiper writes at the ladder ends
        do_req(1, 0, 0, 8'h00);
        chk("R10 low end", int'(tap_sel[0]), 1);
        chk("R11 no busy", int'(busy), 0);
        do_req(1, 0, 0, 8'hFF);
        chk("R10 high end", int'(tap_sel[255]), 1);
        chk("R10 one-hot", $countones(tap_sel), 1);
        do_req(1, 2, 0, 8'h55);
        chk("R3 bad bank write", int'(wiper), 255);
        do_req(0, 1, 0, 0);
        chk("R3 bad bank read", int'(rd_valid), 0);
        do_req(0, 0, 0, 0);
        chk("R3 wiper read", int'(rd_data), 255);

        // R4: load into wiper
        do_req(4, 0, 2, 0);
        chk("R4 load", int'(wiper), pat(2));
        chk("R11 load no busy", int'(busy), 0);
        do_req(4, 1, 3, 0);
        chk("R4 bad bank load", int'(wiper), pat(2));

        // R6: write protect
        wp_n = 1'b0;
        do_req(3, 3, 1, 8'hEE);
        chk("R6 wp no busy", int'(busy), 0);
        do_req(2, 3, 1, 0);
        chk("R6 wp write blocked", int'(rd_data), pat(13));
        do_req(5, 0, 1, 0);
        chk("R6 wp save no busy", int'(busy), 0);
        do_req(2, 0, 1, 0);
        chk("R6 wp save blocked", int'(rd_data), pat(1));
        do_req(1, 0, 0, 8'h3C);
        chk("R6 wiper still writable", int'(wiper), 8'h3C);
        wp_n = 1'b1;

        // R5 / R7: save wiper and time the store
        do_req(5, 0, 3, 0);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk("R7 store length", n, STORE);
        do_req(2, 0, 3, 0);
        chk("R5 saved value", int'(rd_data), 8'h3C);
        do_req(5, 2, 3, 0);
        chk("R5 bad bank no busy", int'(busy), 0);
        do_req(2, 2, 3, 0);
        chk("R5 bad bank no store", int'(rd_data), pat(11));

        // R8: requests during busy are ignored
        do_req(3, 1, 0, 8'h99);
        do_req(1, 0, 0, 8'h11);
        chk("R8 wiper held", int'(wiper), 8'h3C);
        do_req(3, 1, 1, 8'h77);
        do_req(2, 1, 1, 0);
        chk("R8 read ignored", int'(rd_valid), 0);
        wait_idle();
        do_req(2, 1, 1, 0);
        chk("R8 write ignored", int'(rd_data), pat(5));
        do_req(2, 1, 0, 0);
        chk("R1 bank 1 word 0", int'(rd_data), 8'h99);

        // R11: opcodes 6 and 7 do nothing
        do_req(6, 0, 0, 8'h01);
        do_req(7, 0, 0, 8'h02);
        chk("R11 nop wiper", int'(wiper), 8'h3C);
        chk("R11 nop busy", int'(busy), 0);

        // R9: recall follows a changed word 0
        do_req(3, 0, 0, 8'hA5);
        wait_idle();
        do_req(1, 0, 0, 8'h07);
        do_reset();
        chk("R9 recall updated", int'(wiper), 8'hA5);
        chk("R10 recall tap", int'(tap_sel[165]), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule